// File: doc/BRIEF.md
# Framebuffer Raster Scan-Out Address Generator

This block produces the memory word addresses that stream a 16-bit-per-pixel framebuffer to an RGB panel in raster order. A pixel is one 16-bit word, so every pixel strobe becomes exactly one word address. An external display timing generator paces the block. A frame-start pulse opens a frame, each line-start pulse opens the next panel line, and each pixel-advance strobe requests the next pixel of the current line.

The framebuffer is `FB_WIDTH` words wide and `FB_HEIGHT` lines tall, and it may be larger than the panel, so the panel shows a window into it. Several buffers sit back to back above `BASE_ADDR`, each `FB_WIDTH*FB_HEIGHT` words long, so software can draw into one buffer while another is shown. The screen can be cut into horizontal bands. Each band carries its own buffer index, its own X/Y window offset and its own start line. Band 0 is the main view, and with a single band there is no split. The scan can be mirrored horizontally, vertically, or on both axes.

All run-time controls are copied into shadow registers on frame start, so one frame never mixes two settings. The address output is a stream with no back-pressure: the timing generator sets the pace and the consumer must take every beat on which `out_valid` is high. Requirements on `frame_start` and `line_start` also hold when `pix_adv` is idle. A `line_start` or `pix_adv` in the same cycle as `frame_start` is ignored, and so is a `pix_adv` in the same cycle as `line_start`.

Top module: `fb_scan_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_addr` is 0 until the first accepted pixel.
- R2: An accepted `pix_adv` raises `out_valid` for exactly one cycle, at the cycle after the strobe. With no accepted strobe, `out_valid` is 0.
- R3: With no mirroring, pixel x of panel line y reads `BASE_ADDR + buf*FB_WIDTH*FB_HEIGHT + (offy + y)*FB_WIDTH + offx + x`. Here `buf`, `offx` and `offy` belong to the band active on that line.
- R4: With horizontal mirroring (`cfg_mirror_h`=1), x in the formula is replaced by `panel_w-1-x`, so each line is fetched right to left.
- R5: With vertical mirroring (`cfg_mirror_v`=1), y in the formula is replaced by `panel_h-1-y`, so lines are fetched bottom to top.
- R6: Both mirrors can be on at once, and each then applies independently.
- R7: Band i occupies bits `[i*COORD_W +: COORD_W]` of the start, X-offset and Y-offset vectors and bits `[i*BUF_W +: BUF_W]` of the buffer vector. On each line the active band is the highest-indexed band whose start line is at most the scan line count y (before mirroring). If no band qualifies, band 0 is active.
- R8: Panel size, mirrors and the band table take effect only at a `frame_start`. Changing them within a frame does not alter that frame's addresses.
- R9: A `pix_adv` after `panel_w` pixels of the current line, or on a line with y >= `panel_h`, does not raise `out_valid`.
- R10: While the latched panel width or height is zero, `out_valid` stays 0.
- R11: The first `line_start` after `frame_start` opens line 0, and each further `line_start` adds one. Each `line_start` restarts x at 0. A `pix_adv` before the first `line_start` of a frame gives no pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Frame-start pulse; latches the controls |
| line_start | input | 1 | Line-start pulse |
| pix_adv | input | 1 | Pixel-advance strobe |
| cfg_panel_w | input | COORD_W | Visible pixels per line |
| cfg_panel_h | input | COORD_W | Visible lines per frame |
| cfg_mirror_h | input | 1 | Fetch each line right to left |
| cfg_mirror_v | input | 1 | Fetch lines bottom to top |
| cfg_band_start | input | NUM_BAND*COORD_W | Start line of each band |
| cfg_band_buf | input | NUM_BAND*BUF_W | Buffer index of each band |
| cfg_band_off_x | input | NUM_BAND*COORD_W | Window X offset of each band |
| cfg_band_off_y | input | NUM_BAND*COORD_W | Window Y offset of each band |
| out_addr | output | ADDR_W | Pixel word address |
| out_valid | output | 1 | Address beat valid |

## Verification
The bench builds the block with 6-bit coordinates, a 16x12 buffer, two buffers, three bands, a 12-bit address and `BASE_ADDR`=256. The frames are small enough that every pixel of every frame is checked against a model, including one extra strobe past each line's end and one extra line past the panel's bottom. Three bands make room for equal start lines, out-of-order start lines and a band 0 that never qualifies. The nonzero base and the second buffer show up any slip in the buffer-offset arithmetic.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

  // Scan state of the line counter within a frame.
  typedef enum logic {
    ST_PRE_LINE = 1'b0,
    ST_IN_LINE  = 1'b1
  } scan_st_e;

  // Width needed to index n items, never below one bit.
  function automatic int idx_w(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // Reflects a coordinate inside a span of length n when m is set.
  function automatic int mirror_pos(input int c, input int n, input logic m);
    return m ? (n - 1 - c) : c;
  endfunction

endpackage

// File: rtl/fbs_cfg_shadow.sv
module fbs_cfg_shadow #(
  parameter int COORD_W  = 10,
  parameter int BUF_W    = 1,
  parameter int NUM_BAND = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_start_i,
  input  logic [COORD_W-1:0]           panel_w_i,
  input  logic [COORD_W-1:0]           panel_h_i,
  input  logic                         mirror_h_i,
  input  logic                         mirror_v_i,
  input  logic [NUM_BAND*COORD_W-1:0]  band_start_i,
  input  logic [NUM_BAND*BUF_W-1:0]    band_buf_i,
  input  logic [NUM_BAND*COORD_W-1:0]  band_offx_i,
  input  logic [NUM_BAND*COORD_W-1:0]  band_offy_i,
  output logic [COORD_W-1:0]           panel_w_o,
  output logic [COORD_W-1:0]           panel_h_o,
  output logic                         mirror_h_o,
  output logic                         mirror_v_o,
  output logic [NUM_BAND*COORD_W-1:0]  band_start_o,
  output logic [NUM_BAND*BUF_W-1:0]    band_buf_o,
  output logic [NUM_BAND*COORD_W-1:0]  band_offx_o,
  output logic [NUM_BAND*COORD_W-1:0]  band_offy_o,
  output logic                         cfg_err_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      panel_w_o    <= '0;
      panel_h_o    <= '0;
      mirror_h_o   <= 1'b0;
      mirror_v_o   <= 1'b0;
      band_start_o <= '0;
      band_buf_o   <= '0;
      band_offx_o  <= '0;
      band_offy_o  <= '0;
    end else if (frame_start_i) begin
      panel_w_o    <= panel_w_i;
      panel_h_o    <= panel_h_i;
      mirror_h_o   <= mirror_h_i;
      mirror_v_o   <= mirror_v_i;
      band_start_o <= band_start_i;
      band_buf_o   <= band_buf_i;
      band_offx_o  <= band_offx_i;
      band_offy_o  <= band_offy_i;
    end
  end

  // A zero-sized panel is a configuration error.
  assign cfg_err_o = (panel_w_o == '0) || (panel_h_o == '0);

  // R8: the shadow copy only moves on a frame start
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start_i |=> $stable({panel_w_o, panel_h_o, mirror_h_o, mirror_v_o,
                                band_start_o, band_buf_o, band_offx_o, band_offy_o}));

endmodule

// File: rtl/fbs_band_sel.sv
module fbs_band_sel #(
  parameter int COORD_W  = 10,
  parameter int BUF_W    = 1,
  parameter int NUM_BAND = 2
) (
  input  logic [COORD_W-1:0]          line_i,
  input  logic [NUM_BAND*COORD_W-1:0] band_start_i,
  input  logic [NUM_BAND*BUF_W-1:0]   band_buf_i,
  input  logic [NUM_BAND*COORD_W-1:0] band_offx_i,
  input  logic [NUM_BAND*COORD_W-1:0] band_offy_i,
  output logic [BUF_W-1:0]            sel_buf_o,
  output logic [COORD_W-1:0]          sel_offx_o,
  output logic [COORD_W-1:0]          sel_offy_o
);

  localparam int IDX_W = fbs_pkg::idx_w(NUM_BAND);

  logic [NUM_BAND-1:0] hit;
  logic [IDX_W-1:0]    sel_idx;

  for (genvar g = 0; g < NUM_BAND; g++) begin : g_hit
    assign hit[g] = (band_start_i[g*COORD_W +: COORD_W] <= line_i);
  end

  // Highest qualifying band wins; band 0 is the fallback.
  always_comb begin
    sel_idx = '0;
    for (int i = 0; i < NUM_BAND; i++) begin
      if (hit[i]) sel_idx = IDX_W'(i);
    end
  end

  always_comb begin
    sel_buf_o  = '0;
    sel_offx_o = '0;
    sel_offy_o = '0;
    for (int i = 0; i < NUM_BAND; i++) begin
      if (sel_idx == IDX_W'(i)) begin
        sel_buf_o  = band_buf_i[i*BUF_W +: BUF_W];
        sel_offx_o = band_offx_i[i*COORD_W +: COORD_W];
        sel_offy_o = band_offy_i[i*COORD_W +: COORD_W];
      end
    end
  end

endmodule

// File: rtl/fbs_scan_ctr.sv
module fbs_scan_ctr
  import fbs_pkg::*;
#(
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start_i,
  input  logic               line_start_i,
  input  logic               pix_adv_i,
  input  logic [COORD_W-1:0] panel_w_i,
  input  logic [COORD_W-1:0] panel_h_i,
  input  logic               cfg_err_i,
  output logic [COORD_W-1:0] x_o,
  output logic [COORD_W-1:0] y_o,
  output logic [COORD_W-1:0] y_next_o,
  output logic               line_load_o,
  output logic               fire_o
);

  localparam logic [COORD_W-1:0] Y_MAX = '1;

  scan_st_e          st_q;
  logic [COORD_W-1:0] x_q, y_q;

  assign line_load_o = line_start_i & ~frame_start_i;

  // First line of a frame is 0; later lines step by one and saturate.
  assign y_next_o = (st_q == ST_PRE_LINE) ? '0 :
                    (y_q == Y_MAX)        ? y_q : y_q + 1'b1;

  assign fire_o = pix_adv_i & ~line_start_i & ~frame_start_i &
                  (st_q == ST_IN_LINE) & (y_q < panel_h_i) &
                  (x_q < panel_w_i) & ~cfg_err_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_PRE_LINE;
      x_q  <= '0;
      y_q  <= '0;
    end else if (frame_start_i) begin
      st_q <= ST_PRE_LINE;
      x_q  <= '0;
      y_q  <= '0;
    end else if (line_load_o) begin
      st_q <= ST_IN_LINE;
      x_q  <= '0;
      y_q  <= y_next_o;
    end else if (fire_o) begin
      x_q  <= x_q + 1'b1;
    end
  end

  assign x_o = x_q;
  assign y_o = y_q;

  // R9: the column count never passes the latched width
  a_r9_x_limit: assert property (@(posedge clk) disable iff (!rst_n)
    x_q <= panel_w_i);

  // R11: the first line of a frame is line 0
  a_r11_first_line: assert property (@(posedge clk) disable iff (!rst_n)
    (line_load_o && st_q == ST_PRE_LINE) |=> (y_q == '0 && x_q == '0));

  // R11: later lines step by one
  a_r11_line_step: assert property (@(posedge clk) disable iff (!rst_n)
    (line_load_o && st_q == ST_IN_LINE && y_q != Y_MAX) |=> (y_q == $past(y_q) + 1'b1));

endmodule

// File: rtl/fbs_addr_gen.sv
module fbs_addr_gen #(
  parameter int ADDR_W    = 21,
  parameter int COORD_W   = 10,
  parameter int BUF_W     = 1,
  parameter int FB_WIDTH  = 1024,
  parameter int FB_HEIGHT = 600,
  parameter int BASE_ADDR = 0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_load_i,
  input  logic               fire_i,
  input  logic [COORD_W-1:0] y_next_i,
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] panel_w_i,
  input  logic [COORD_W-1:0] panel_h_i,
  input  logic               mirror_h_i,
  input  logic               mirror_v_i,
  input  logic [BUF_W-1:0]   sel_buf_i,
  input  logic [COORD_W-1:0] sel_offx_i,
  input  logic [COORD_W-1:0] sel_offy_i,
  output logic [ADDR_W-1:0]  addr_o,
  output logic               valid_o
);

  localparam int BUF_WORDS = FB_WIDTH * FB_HEIGHT;

  logic [COORD_W-1:0] y_eff, x_eff;
  logic [ADDR_W-1:0]  row_base_d, row_base_q;

  assign y_eff = COORD_W'(fbs_pkg::mirror_pos(int'(y_next_i), int'(panel_h_i), mirror_v_i));
  assign x_eff = COORD_W'(fbs_pkg::mirror_pos(int'(x_i), int'(panel_w_i), mirror_h_i));

  // Row start address, formed once per line.
  assign row_base_d = ADDR_W'(BASE_ADDR)
                    + ADDR_W'(BUF_WORDS) * ADDR_W'(sel_buf_i)
                    + (ADDR_W'(sel_offy_i) + ADDR_W'(y_eff)) * ADDR_W'(FB_WIDTH)
                    + ADDR_W'(sel_offx_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_base_q <= '0;
      addr_o     <= '0;
      valid_o    <= 1'b0;
    end else begin
      if (line_load_i) row_base_q <= row_base_d;
      if (fire_i)      addr_o     <= row_base_q + ADDR_W'(x_eff);
      valid_o <= fire_i;
    end
  end

endmodule

// File: rtl/fb_scan_addr_gen.sv
module fb_scan_addr_gen
  import fbs_pkg::*;
#(
  parameter int ADDR_W    = 21,
  parameter int COORD_W   = 10,
  parameter int FB_WIDTH  = 1024,
  parameter int FB_HEIGHT = 600,
  parameter int NUM_BUF   = 2,
  parameter int NUM_BAND  = 2,
  parameter int BASE_ADDR = 0,
  localparam int BUF_W    = idx_w(NUM_BUF)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        frame_start,
  input  logic                        line_start,
  input  logic                        pix_adv,
  input  logic [COORD_W-1:0]          cfg_panel_w,
  input  logic [COORD_W-1:0]          cfg_panel_h,
  input  logic                        cfg_mirror_h,
  input  logic                        cfg_mirror_v,
  input  logic [NUM_BAND*COORD_W-1:0] cfg_band_start,
  input  logic [NUM_BAND*BUF_W-1:0]   cfg_band_buf,
  input  logic [NUM_BAND*COORD_W-1:0] cfg_band_off_x,
  input  logic [NUM_BAND*COORD_W-1:0] cfg_band_off_y,
  output logic [ADDR_W-1:0]           out_addr,
  output logic                        out_valid
);

  logic [COORD_W-1:0]          sh_panel_w, sh_panel_h;
  logic                        sh_mirror_h, sh_mirror_v;
  logic [NUM_BAND*COORD_W-1:0] sh_band_start, sh_band_offx, sh_band_offy;
  logic [NUM_BAND*BUF_W-1:0]   sh_band_buf;
  logic                        cfg_err;

  logic [COORD_W-1:0] scan_x, scan_y, scan_y_next;
  logic               line_load, fire;

  logic [BUF_W-1:0]   sel_buf;
  logic [COORD_W-1:0] sel_offx, sel_offy;

  fbs_cfg_shadow #(
    .COORD_W (COORD_W),
    .BUF_W   (BUF_W),
    .NUM_BAND(NUM_BAND)
  ) u_shadow (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start_i(frame_start),
    .panel_w_i    (cfg_panel_w),
    .panel_h_i    (cfg_panel_h),
    .mirror_h_i   (cfg_mirror_h),
    .mirror_v_i   (cfg_mirror_v),
    .band_start_i (cfg_band_start),
    .band_buf_i   (cfg_band_buf),
    .band_offx_i  (cfg_band_off_x),
    .band_offy_i  (cfg_band_off_y),
    .panel_w_o    (sh_panel_w),
    .panel_h_o    (sh_panel_h),
    .mirror_h_o   (sh_mirror_h),
    .mirror_v_o   (sh_mirror_v),
    .band_start_o (sh_band_start),
    .band_buf_o   (sh_band_buf),
    .band_offx_o  (sh_band_offx),
    .band_offy_o  (sh_band_offy),
    .cfg_err_o    (cfg_err)
  );

  fbs_scan_ctr #(
    .COORD_W(COORD_W)
  ) u_scan (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_start_i(frame_start),
    .line_start_i (line_start),
    .pix_adv_i    (pix_adv),
    .panel_w_i    (sh_panel_w),
    .panel_h_i    (sh_panel_h),
    .cfg_err_i    (cfg_err),
    .x_o          (scan_x),
    .y_o          (scan_y),
    .y_next_o     (scan_y_next),
    .line_load_o  (line_load),
    .fire_o       (fire)
  );

  fbs_band_sel #(
    .COORD_W (COORD_W),
    .BUF_W   (BUF_W),
    .NUM_BAND(NUM_BAND)
  ) u_band (
    .line_i      (scan_y_next),
    .band_start_i(sh_band_start),
    .band_buf_i  (sh_band_buf),
    .band_offx_i (sh_band_offx),
    .band_offy_i (sh_band_offy),
    .sel_buf_o   (sel_buf),
    .sel_offx_o  (sel_offx),
    .sel_offy_o  (sel_offy)
  );

  fbs_addr_gen #(
    .ADDR_W   (ADDR_W),
    .COORD_W  (COORD_W),
    .BUF_W    (BUF_W),
    .FB_WIDTH (FB_WIDTH),
    .FB_HEIGHT(FB_HEIGHT),
    .BASE_ADDR(BASE_ADDR)
  ) u_addr (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_load_i(line_load),
    .fire_i     (fire),
    .y_next_i   (scan_y_next),
    .x_i        (scan_x),
    .panel_w_i  (sh_panel_w),
    .panel_h_i  (sh_panel_h),
    .mirror_h_i (sh_mirror_h),
    .mirror_v_i (sh_mirror_v),
    .sel_buf_i  (sel_buf),
    .sel_offx_i (sel_offx),
    .sel_offy_i (sel_offy),
    .addr_o     (out_addr),
    .valid_o    (out_valid)
  );

  // R2: a valid beat always follows a pixel strobe
  a_r2_valid_needs_adv: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(pix_adv));

  // R10: a zero-sized panel yields no beats
  a_r10_err_silent: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !out_valid);

  // R9: strobes below the last panel line yield no beats
  a_r9_row_limit: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_adv && scan_y >= sh_panel_h) |=> !out_valid);

endmodule

// File: tb/fb_scan_addr_gen_tb.sv
module fb_scan_addr_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int CW   = 6;
  localparam int AW   = 12;
  localparam int FBW  = 16;
  localparam int FBH  = 12;
  localparam int NBUF = 2;
  localparam int NB   = 3;
  localparam int BASE = 256;

  typedef struct packed {
    logic [5:0] pw;
    logic [5:0] ph;
    logic       mh;
    logic       mv;
    logic [5:0] s0; logic [5:0] s1; logic [5:0] s2;
    logic       b0; logic       b1; logic       b2;
    logic [5:0] x0; logic [5:0] x1; logic [5:0] x2;
    logic [5:0] y0; logic [5:0] y1; logic [5:0] y2;
  } vec_t;

  localparam int NV = 6;
  // fields: pw ph mh mv | s0 s1 s2 | b0 b1 b2 | offx0..2 | offy0..2
  localparam vec_t VECS [NV] = '{
    '{6'd4, 6'd3, 1'b0, 1'b0, 6'd0, 6'd63, 6'd63, 1'b0, 1'b0, 1'b0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0, 6'd0},
    '{6'd5, 6'd4, 1'b1, 1'b0, 6'd0, 6'd63, 6'd63, 1'b1, 1'b0, 1'b0, 6'd2, 6'd0, 6'd0, 6'd3, 6'd0, 6'd0},
    '{6'd4, 6'd4, 1'b0, 1'b1, 6'd0, 6'd63, 6'd63, 1'b0, 1'b0, 1'b0, 6'd1, 6'd0, 6'd0, 6'd1, 6'd0, 6'd0},
    '{6'd3, 6'd5, 1'b1, 1'b1, 6'd0, 6'd2,  6'd4,  1'b0, 1'b1, 1'b0, 6'd0, 6'd4, 6'd7, 6'd0, 6'd2, 6'd6},
    '{6'd6, 6'd6, 1'b0, 1'b0, 6'd0, 6'd1,  6'd1,  1'b0, 1'b1, 1'b1, 6'd0, 6'd3, 6'd5, 6'd2, 6'd3, 6'd0},
    '{6'd4, 6'd5, 1'b0, 1'b1, 6'd5, 6'd3,  6'd2,  1'b1, 1'b0, 1'b1, 6'd8, 6'd1, 6'd2, 6'd4, 6'd0, 6'd6}
  };
  localparam string VTAG [NV] = '{"R3", "R4", "R5", "R6", "R7", "R7"};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frame_start = 1'b0;
  logic          line_start = 1'b0;
  logic          pix_adv = 1'b0;
  logic [CW-1:0] cfg_panel_w = '0;
  logic [CW-1:0] cfg_panel_h = '0;
  logic          cfg_mirror_h = 1'b0;
  logic          cfg_mirror_v = 1'b0;
  logic [NB*CW-1:0] cfg_band_start = '0;
  logic [NB-1:0]    cfg_band_buf = '0;
  logic [NB*CW-1:0] cfg_band_off_x = '0;
  logic [NB*CW-1:0] cfg_band_off_y = '0;
  logic [AW-1:0] out_addr;
  logic          out_valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fb_scan_addr_gen #(
    .ADDR_W(AW), .COORD_W(CW), .FB_WIDTH(FBW), .FB_HEIGHT(FBH),
    .NUM_BUF(NBUF), .NUM_BAND(NB), .BASE_ADDR(BASE)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .line_start(line_start),
    .pix_adv(pix_adv), .cfg_panel_w(cfg_panel_w), .cfg_panel_h(cfg_panel_h),
    .cfg_mirror_h(cfg_mirror_h), .cfg_mirror_v(cfg_mirror_v),
    .cfg_band_start(cfg_band_start), .cfg_band_buf(cfg_band_buf),
    .cfg_band_off_x(cfg_band_off_x), .cfg_band_off_y(cfg_band_off_y),
    .out_addr(out_addr), .out_valid(out_valid)
  );

  function automatic int model(vec_t v, int y, int x);
    int band, ye, xe, b, ox, oy;
    band = 0;
    if (int'(v.s1) <= y) band = 1;
    if (int'(v.s2) <= y) band = 2;
    b  = (band == 0) ? int'(v.b0) : (band == 1) ? int'(v.b1) : int'(v.b2);
    ox = (band == 0) ? int'(v.x0) : (band == 1) ? int'(v.x1) : int'(v.x2);
    oy = (band == 0) ? int'(v.y0) : (band == 1) ? int'(v.y1) : int'(v.y2);
    ye = v.mv ? int'(v.ph) - 1 - y : y;
    xe = v.mh ? int'(v.pw) - 1 - x : x;
    return BASE + b * FBW * FBH + (oy + ye) * FBW + ox + xe;
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_vec(vec_t v);
    cfg_panel_w    = v.pw;
    cfg_panel_h    = v.ph;
    cfg_mirror_h   = v.mh;
    cfg_mirror_v   = v.mv;
    cfg_band_start = {v.s2, v.s1, v.s0};
    cfg_band_buf   = {v.b2, v.b1, v.b0};
    cfg_band_off_x = {v.x2, v.x1, v.x0};
    cfg_band_off_y = {v.y2, v.y1, v.y0};
  endtask

  task automatic pulse_frame();
    @(negedge clk) frame_start = 1'b1;
    @(negedge clk) frame_start = 1'b0;
  endtask

  task automatic pulse_line();
    @(negedge clk) line_start = 1'b1;
    @(negedge clk) line_start = 1'b0;
  endtask

  // One strobe; result is registered at the next edge and sampled at the negedge after it.
  task automatic pix_expect(string req, bit exp_v, int exp_a);
    @(negedge clk) pix_adv = 1'b1;
    @(negedge clk) pix_adv = 1'b0;
    check(req, int'(out_valid), int'(exp_v));
    if (exp_v) check(req, int'(out_addr), exp_a);
  endtask

  task automatic run_frame(vec_t v, string tag);
    pulse_frame();
    for (int y = 0; y <= int'(v.ph); y++) begin
      pulse_line();
      for (int x = 0; x <= int'(v.pw); x++) begin
        if (y < int'(v.ph) && x < int'(v.pw))
          pix_expect(tag, 1'b1, model(v, y, x));
        else
          pix_expect("R9", 1'b0, 0);
      end
    end
  endtask

  initial begin
    vec_t zw, zh;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_addr), 0);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(out_valid), 0);
    check("R1", int'(out_addr), 0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      load_vec(VECS[i]);
      run_frame(VECS[i], VTAG[i]);
    end

    // R2: idle cycle after a beat gives no beat
    @(negedge clk);
    check("R2", int'(out_valid), 0);

    // R11: strobe before the first line of a frame gives nothing; then line 0
    load_vec(VECS[0]);
    pulse_frame();
    pix_expect("R11", 1'b0, 0);
    pulse_line();
    pix_expect("R11", 1'b1, model(VECS[0], 0, 0));
    pix_expect("R11", 1'b1, model(VECS[0], 0, 1));
    pulse_line();
    pix_expect("R11", 1'b1, model(VECS[0], 1, 0));

    // R8: mid-frame changes wait for the next frame start
    load_vec(VECS[0]);
    pulse_frame();
    load_vec(VECS[3]);
    pulse_line();
    pix_expect("R8", 1'b1, model(VECS[0], 0, 0));
    pix_expect("R8", 1'b1, model(VECS[0], 0, 1));
    pulse_line();
    pix_expect("R8", 1'b1, model(VECS[0], 1, 0));
    pulse_frame();
    pulse_line();
    pix_expect("R8", 1'b1, model(VECS[3], 0, 0));

    // R10: zero width, then zero height
    zw = VECS[0]; zw.pw = 6'd0;
    load_vec(zw);
    pulse_frame();
    pulse_line();
    pix_expect("R10", 1'b0, 0);
    pix_expect("R10", 1'b0, 0);
    zh = VECS[0]; zh.ph = 6'd0;
    load_vec(zh);
    pulse_frame();
    pulse_line();
    pix_expect("R10", 1'b0, 0);
    load_vec(VECS[2]);
    pulse_frame();
    pulse_line();
    pix_expect("R10", 1'b1, model(VECS[2], 0, 0));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule